// File: doc/BRIEF.md
# Execute-Stage Squash Redirect Generator

This block sits at the end of the execute stage of an out-of-order core. Each cycle it receives up to `ISSUE_W` instruction slots from the issue stage. It decides which of them execute, given a functional-unit budget. It then checks every executed slot for two faults. The first is a control-flow misprediction: the resolved next PC differs from the predicted one. The second is a memory-ordering violation flagged by the load/store queue.

When any executed slot needs a squash, the block sends commit a single redirect packet. The packet is built from the oldest offending instruction. In the same cycle the block raises a request that moves the stage into its squashing state. When the chosen fault is a memory-ordering violation, the block also reports to the instruction queue the faulting instruction and the older access that broke the ordering.

Slots marked as already squashed bypass execution and are handed straight to commit. The block keeps three event counters: mispredicted branches that were predicted taken, memory-ordering violations, and squashed slots skipped. All outputs are registered and appear one clock after the slot inputs.

Top module: `squash_redirect_gen`

## Requirements
- R1: Slot i is processed (its bit set in `done_mask`) only if slots 0..i are all valid and the number of non-squashed slots among 0..i-1 is below `fu_budget`. Processing stops at the first empty slot, at the end of the issue width, or once the budget is spent. Squashed slots use no budget. Faults in unprocessed slots are ignored.
- R2: A branch mispredict is a processed, non-squashed slot with `slot_ctrl`=1 and `slot_tgt` ≠ `slot_pnpc`. Its packet carries `sq_seq`=slot sequence number, `sq_mispc`=slot PC, `sq_npc`=resolved target, and `sq_mispred`=1.
- R3: In a mispredict packet, `sq_taken` is 1 exactly when the resolved target differs from the slot PC plus 4.
- R4: A memory-ordering violation is a processed, non-squashed slot with `slot_mem`=1 and `slot_lsq_viol`=1. Its packet carries only `sq_seq` and `sq_npc`; `sq_mispc`, `sq_mispred` and `sq_taken` are 0.
- R5: When one slot is both a mispredict and a violation, it is treated as a mispredict. It raises no instruction-queue report and does not count as a violation.
- R6: When the selected fault is a violation, `iq_viol_vld`=1. `iq_inst_seq` then carries the faulting slot's sequence number and `iq_src_seq` carries `lsq_violator_seq`.
- R7: When several slots need a squash in one cycle, the packet comes from the slot with the lowest sequence number (unsigned compare).
- R8: A processed squashed slot sets its bit in `pass_mask`. It raises no squash, and it adds one to `cnt_sqd_skip`.
- R9: `cnt_pt_misp` adds the number of processed mispredict slots whose `slot_ptaken`=1. `cnt_mem_viol` adds the number of violation slots (per R5). Both counters wrap.
- R10: Outputs follow the inputs by one clock. `stage_squash_req` equals `sq_vld`. In a cycle with no squash, all packet and report fields are 0.
- R11: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fu_budget | input | BUD_W | Functional units free this cycle |
| slot_vld | input | ISSUE_W | Slot holds an instruction |
| slot_sqd | input | ISSUE_W | Instruction already squashed |
| slot_ctrl | input | ISSUE_W | Control-flow instruction |
| slot_mem | input | ISSUE_W | Memory instruction |
| slot_lsq_viol | input | ISSUE_W | Load/store queue reports an ordering violation for this slot |
| slot_ptaken | input | ISSUE_W | Branch was predicted taken |
| slot_seq | input | ISSUE_W*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W |
| slot_pc | input | ISSUE_W*PC_W | Instruction PCs |
| slot_tgt | input | ISSUE_W*PC_W | Resolved next PCs |
| slot_pnpc | input | ISSUE_W*PC_W | Predicted next PCs |
| lsq_violator_seq | input | SEQ_W | Sequence number of the older violating access |
| done_mask | output | ISSUE_W | Slots processed last cycle |
| pass_mask | output | ISSUE_W | Squashed slots passed to commit |
| sq_vld | output | 1 | Redirect packet valid |
| sq_seq | output | SEQ_W | Sequence number of the squashing instruction |
| sq_mispc | output | PC_W | PC of the mispredicted instruction |
| sq_npc | output | PC_W | Corrected next PC |
| sq_mispred | output | 1 | Packet is a branch mispredict |
| sq_taken | output | 1 | Corrected branch direction |
| stage_squash_req | output | 1 | Request to enter the squashing state |
| iq_viol_vld | output | 1 | Violation report to the instruction queue |
| iq_inst_seq | output | SEQ_W | Faulting instruction |
| iq_src_seq | output | SEQ_W | Violating older access |
| cnt_pt_misp | output | CNT_W | Predicted-taken mispredict count |
| cnt_mem_viol | output | CNT_W | Memory-order violation count |
| cnt_sqd_skip | output | CNT_W | Squashed slots skipped |

## Verification
The hardest situation to reach is a cycle where the oldest fault does not sit in the lowest slot, and where other faults of the other kind are present at the same time. In that cycle the selection, the packet type and the counters must all disagree with a naive slot-0-first reading. The stimulus places a violation in slot 0 with a large sequence number and two predicted-taken mispredicts further up with smaller numbers. It then checks the packet kind and both counter deltas.

A second hard case mixes squashed slots with a small budget. The bench puts squashed slots ahead of live ones to show that the budget is spent only by live slots.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [1:0] {
    SQK_NONE   = 2'd0,
    SQK_BRANCH = 2'd1,
    SQK_MEMORD = 2'd2
  } sq_kind_e;

  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 32; k++) n += int'(v[k]);
    return n;
  endfunction
endpackage

// File: rtl/sqr_exec_limit.sv
module sqr_exec_limit #(
  parameter int unsigned N     = 4,
  parameter int unsigned BUD_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     sqd,
  input  logic [BUD_W-1:0] budget,
  output logic [N-1:0]     processed
);
  logic [BUD_W-1:0] used;
  logic             run;

  always_comb begin
    run  = 1'b1;
    used = '0;
    for (int i = 0; i < N; i++) begin
      run          = run & vld[i];
      processed[i] = run && (used < budget);
      if (processed[i] && !sqd[i]) used = used + 1'b1;
    end
  end

  AST_FU_BUDGET: assert property (@(posedge clk) disable iff (rst)
    $countones(processed & ~sqd) <= int'(budget)); // R1

  for (genvar g = 1; g < N; g++) begin : g_gap
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
      processed[g] |-> (processed[g-1] && vld[g])); // R1
  end
endmodule

// File: rtl/sqr_slot_check.sv
module sqr_slot_check
  import sqr_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            processed,
  input  logic            sqd,
  input  logic            ctrl,
  input  logic            mem,
  input  logic            lsq_viol,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] tgt,
  input  logic [PC_W-1:0] pnpc,
  output sq_kind_e        kind,
  output logic            taken_fix
);
  function automatic logic [PC_W-1:0] fall_through(input logic [PC_W-1:0] a);
    return a + PC_W'(INSN_BYTES);
  endfunction

  function automatic logic dir_taken(input logic [PC_W-1:0] a,
                                     input logic [PC_W-1:0] t);
    return t != fall_through(a);
  endfunction

  logic live, misp, viol;

  assign live      = processed & ~sqd;
  assign misp      = live & ctrl & (tgt != pnpc);
  assign viol      = live & mem & lsq_viol;
  assign taken_fix = dir_taken(pc, tgt);

  always_comb begin
    if (misp)      kind = SQK_BRANCH;
    else if (viol) kind = SQK_MEMORD;
    else           kind = SQK_NONE;
  end

  AST_SQD_SILENT: assert property (@(posedge clk) disable iff (rst)
    sqd |-> (kind == SQK_NONE)); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !processed |-> (kind == SQK_NONE)); // R1
endmodule

// File: rtl/sqr_oldest_sel.sv
module sqr_oldest_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       cand,
  input  logic [N*SEQ_W-1:0] seq,
  output logic               sel_vld,
  output logic [IDX_W-1:0]   sel_idx,
  output logic [N-1:0]       sel_mask
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!sel_vld || seq[i*SEQ_W +: SEQ_W] < best)) begin
        sel_vld = 1'b1;
        sel_idx = IDX_W'(i);
        best    = seq[i*SEQ_W +: SEQ_W];
      end
    end
    sel_mask = '0;
    if (sel_vld) sel_mask[sel_idx] = 1'b1;
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_mask) && ((sel_mask & ~cand) == '0)); // R7

  for (genvar g = 0; g < N; g++) begin : g_age
    AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (rst)
      (sel_vld && cand[g]) |-> (best <= seq[g*SEQ_W +: SEQ_W])); // R7
  end
endmodule

// File: rtl/sqr_event_counters.sv
module sqr_event_counters
  import sqr_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pt_misp_mask,
  input  logic [N-1:0]     viol_mask,
  input  logic [N-1:0]     sqd_mask,
  output logic [CNT_W-1:0] cnt_pt_misp,
  output logic [CNT_W-1:0] cnt_mem_viol,
  output logic [CNT_W-1:0] cnt_sqd_skip
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_pt_misp  <= '0;
      cnt_mem_viol <= '0;
      cnt_sqd_skip <= '0;
    end else begin
      cnt_pt_misp  <= cnt_pt_misp  + CNT_W'(count_ones(32'(pt_misp_mask)));
      cnt_mem_viol <= cnt_mem_viol + CNT_W'(count_ones(32'(viol_mask)));
      cnt_sqd_skip <= cnt_sqd_skip + CNT_W'(count_ones(32'(sqd_mask)));
    end
  end

  AST_VIOL_CNT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (viol_mask == '0) |=> $stable(cnt_mem_viol)); // R9
  AST_PT_CNT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (pt_misp_mask == '0) |=> $stable(cnt_pt_misp)); // R9
endmodule

// File: rtl/squash_redirect_gen.sv
module squash_redirect_gen
  import sqr_pkg::*;
#(
  parameter int unsigned ISSUE_W = 4,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned BUD_W  = $clog2(ISSUE_W + 1),
  localparam int unsigned IDX_W  = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BUD_W-1:0]         fu_budget,
  input  logic [ISSUE_W-1:0]       slot_vld,
  input  logic [ISSUE_W-1:0]       slot_sqd,
  input  logic [ISSUE_W-1:0]       slot_ctrl,
  input  logic [ISSUE_W-1:0]       slot_mem,
  input  logic [ISSUE_W-1:0]       slot_lsq_viol,
  input  logic [ISSUE_W-1:0]       slot_ptaken,
  input  logic [ISSUE_W*SEQ_W-1:0] slot_seq,
  input  logic [ISSUE_W*PC_W-1:0]  slot_pc,
  input  logic [ISSUE_W*PC_W-1:0]  slot_tgt,
  input  logic [ISSUE_W*PC_W-1:0]  slot_pnpc,
  input  logic [SEQ_W-1:0]         lsq_violator_seq,
  output logic [ISSUE_W-1:0]       done_mask,
  output logic [ISSUE_W-1:0]       pass_mask,
  output logic                     sq_vld,
  output logic [SEQ_W-1:0]         sq_seq,
  output logic [PC_W-1:0]          sq_mispc,
  output logic [PC_W-1:0]          sq_npc,
  output logic                     sq_mispred,
  output logic                     sq_taken,
  output logic                     stage_squash_req,
  output logic                     iq_viol_vld,
  output logic [SEQ_W-1:0]         iq_inst_seq,
  output logic [SEQ_W-1:0]         iq_src_seq,
  output logic [CNT_W-1:0]         cnt_pt_misp,
  output logic [CNT_W-1:0]         cnt_mem_viol,
  output logic [CNT_W-1:0]         cnt_sqd_skip
);
  logic [ISSUE_W-1:0] processed;
  logic [ISSUE_W-1:0] branch_m, memord_m, need_m, taken_m;
  logic               sel_vld;
  logic [IDX_W-1:0]   sel_idx;
  logic [ISSUE_W-1:0] sel_mask;
  sq_kind_e           kind_a [ISSUE_W];

  sqr_exec_limit #(.N(ISSUE_W), .BUD_W(BUD_W)) u_limit (
    .clk(clk), .rst(rst), .vld(slot_vld), .sqd(slot_sqd),
    .budget(fu_budget), .processed(processed)
  );

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_slot
    sqr_slot_check #(.PC_W(PC_W)) u_chk (
      .clk(clk), .rst(rst),
      .processed(processed[g]), .sqd(slot_sqd[g]), .ctrl(slot_ctrl[g]),
      .mem(slot_mem[g]), .lsq_viol(slot_lsq_viol[g]),
      .pc(slot_pc[g*PC_W +: PC_W]), .tgt(slot_tgt[g*PC_W +: PC_W]),
      .pnpc(slot_pnpc[g*PC_W +: PC_W]),
      .kind(kind_a[g]), .taken_fix(taken_m[g])
    );
    assign branch_m[g] = (kind_a[g] == SQK_BRANCH);
    assign memord_m[g] = (kind_a[g] == SQK_MEMORD);
    assign need_m[g]   = branch_m[g] | memord_m[g];
  end

  sqr_oldest_sel #(.N(ISSUE_W), .SEQ_W(SEQ_W)) u_sel (
    .clk(clk), .rst(rst), .cand(need_m), .seq(slot_seq),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_mask(sel_mask)
  );

  sqr_event_counters #(.N(ISSUE_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .pt_misp_mask(branch_m & slot_ptaken),
    .viol_mask(memord_m),
    .sqd_mask(processed & slot_sqd),
    .cnt_pt_misp(cnt_pt_misp), .cnt_mem_viol(cnt_mem_viol),
    .cnt_sqd_skip(cnt_sqd_skip)
  );

  logic             sel_branch;
  logic [SEQ_W-1:0] sel_seq;
  logic [PC_W-1:0]  sel_pc, sel_tgt;

  assign sel_branch = |(sel_mask & branch_m);
  assign sel_seq    = slot_seq[sel_idx*SEQ_W +: SEQ_W];
  assign sel_pc     = slot_pc[sel_idx*PC_W +: PC_W];
  assign sel_tgt    = slot_tgt[sel_idx*PC_W +: PC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_mask        <= '0;
      pass_mask        <= '0;
      sq_vld           <= 1'b0;
      sq_seq           <= '0;
      sq_mispc         <= '0;
      sq_npc           <= '0;
      sq_mispred       <= 1'b0;
      sq_taken         <= 1'b0;
      stage_squash_req <= 1'b0;
      iq_viol_vld      <= 1'b0;
      iq_inst_seq      <= '0;
      iq_src_seq       <= '0;
    end else begin
      done_mask        <= processed;
      pass_mask        <= processed & slot_sqd;
      sq_vld           <= sel_vld;
      stage_squash_req <= sel_vld;
      sq_seq           <= sel_vld ? sel_seq : '0;
      sq_npc           <= sel_vld ? sel_tgt : '0;
      sq_mispred       <= sel_vld & sel_branch;
      sq_mispc         <= (sel_vld && sel_branch) ? sel_pc : '0;
      sq_taken         <= sel_vld & sel_branch & |(sel_mask & taken_m);
      iq_viol_vld      <= sel_vld & ~sel_branch;
      iq_inst_seq      <= (sel_vld && !sel_branch) ? sel_seq : '0;
      iq_src_seq       <= (sel_vld && !sel_branch) ? lsq_violator_seq : '0;
    end
  end

  AST_VIOL_PKT_LEAN: assert property (@(posedge clk) disable iff (rst)
    (sq_vld && !sq_mispred) |-> (sq_mispc == '0 && !sq_taken)); // R4
  AST_IQ_ONLY_VIOL: assert property (@(posedge clk) disable iff (rst)
    iq_viol_vld |-> (sq_vld && !sq_mispred)); // R6
  AST_PKT_NEEDS_WORK: assert property (@(posedge clk) disable iff (rst)
    sq_vld |-> (done_mask != '0)); // R1
  AST_PASS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    (pass_mask & ~done_mask) == '0); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sq_vld |-> (sq_seq == '0 && sq_npc == '0 && !sq_mispred && !iq_viol_vld)); // R10
endmodule

// File: tb/test_squash_redirect_gen.sv
module test_squash_redirect_gen;
  localparam int N = 4, SW = 16, PW = 32, CW = 16, BW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [BW-1:0] fu_budget;
  logic [N-1:0]  b_vld, b_sqd, b_ctrl, b_mem, b_lv, b_pt;
  logic [SW-1:0] b_seq [N];
  logic [PW-1:0] b_pc [N], b_tgt [N], b_pnpc [N];
  logic [SW-1:0] viol_src;
  logic [N*SW-1:0] p_seq;
  logic [N*PW-1:0] p_pc, p_tgt, p_pnpc;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      p_seq[i*SW +: SW]  = b_seq[i];
      p_pc[i*PW +: PW]   = b_pc[i];
      p_tgt[i*PW +: PW]  = b_tgt[i];
      p_pnpc[i*PW +: PW] = b_pnpc[i];
    end
  end

  logic [N-1:0]  done_mask, pass_mask;
  logic          sq_vld, sq_mispred, sq_taken, stage_squash_req, iq_viol_vld;
  logic [SW-1:0] sq_seq, iq_inst_seq, iq_src_seq;
  logic [PW-1:0] sq_mispc, sq_npc;
  logic [CW-1:0] cnt_pt_misp, cnt_mem_viol, cnt_sqd_skip;

  squash_redirect_gen #(.ISSUE_W(N), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) i_squash_redirect_gen (
    .clk(clk), .rst(rst), .fu_budget(fu_budget),
    .slot_vld(b_vld), .slot_sqd(b_sqd), .slot_ctrl(b_ctrl), .slot_mem(b_mem),
    .slot_lsq_viol(b_lv), .slot_ptaken(b_pt), .slot_seq(p_seq), .slot_pc(p_pc),
    .slot_tgt(p_tgt), .slot_pnpc(p_pnpc), .lsq_violator_seq(viol_src),
    .done_mask(done_mask), .pass_mask(pass_mask), .sq_vld(sq_vld), .sq_seq(sq_seq),
    .sq_mispc(sq_mispc), .sq_npc(sq_npc), .sq_mispred(sq_mispred), .sq_taken(sq_taken),
    .stage_squash_req(stage_squash_req), .iq_viol_vld(iq_viol_vld),
    .iq_inst_seq(iq_inst_seq), .iq_src_seq(iq_src_seq),
    .cnt_pt_misp(cnt_pt_misp), .cnt_mem_viol(cnt_mem_viol), .cnt_sqd_skip(cnt_sqd_skip)
  );

  int checks = 0, errors = 0;
  int e_pt = 0, e_mv = 0, e_sq = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_slots();
    fu_budget = 3'd4; b_vld = '0; b_sqd = '0; b_ctrl = '0; b_mem = '0;
    b_lv = '0; b_pt = '0; viol_src = '0;
    for (int i = 0; i < N; i++) begin
      b_seq[i] = SW'(100 + i); b_pc[i] = PW'(32'h100 + 16 * i);
      b_tgt[i] = b_pc[i] + 4; b_pnpc[i] = b_pc[i] + 4;
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_counts(string req);
    chk(req, "cnt_pt_misp", cnt_pt_misp, e_pt);
    chk(req, "cnt_mem_viol", cnt_mem_viol, e_mv);
    chk(req, "cnt_sqd_skip", cnt_sqd_skip, e_sq);
  endtask

  task automatic t_reset();
    chk("R11", "done_mask", done_mask, 0);
    chk("R11", "sq_vld", sq_vld, 0);
    chk("R11", "stage_squash_req", stage_squash_req, 0);
    chk("R11", "iq_viol_vld", iq_viol_vld, 0);
    chk_counts("R11");
  endtask

  task automatic t_limits();
    clear_slots(); b_vld = 4'hF; fu_budget = 3'd2;
    b_ctrl[2] = 1'b1; b_tgt[2] = 32'h9000;
    step();
    chk("R1", "done_mask budget 2", done_mask, 4'b0011);
    chk("R1", "unprocessed mispredict ignored", sq_vld, 0);
    clear_slots(); b_vld = 4'b1011; step();
    chk("R1", "done_mask gap", done_mask, 4'b0011);
    clear_slots(); b_vld = 4'hF; step();
    chk("R1", "done_mask full width", done_mask, 4'hF);
    clear_slots(); b_vld = 4'hF; fu_budget = 3'd0; step();
    chk("R1", "done_mask budget 0", done_mask, 0);
    clear_slots(); b_vld = 4'hF; b_sqd = 4'b0011; fu_budget = 3'd2; step();
    e_sq += 2;
    chk("R1", "squashed use no budget", done_mask, 4'hF);
    chk("R8", "pass_mask", pass_mask, 4'b0011);
    chk_counts("R8");
  endtask

  task automatic t_branch();
    clear_slots(); b_vld = 4'b0011; b_ctrl[1] = 1'b1; b_seq[1] = 16'h21;
    b_pc[1] = 32'h1000; b_tgt[1] = 32'h2000; b_pnpc[1] = 32'h1004;
    step();
    chk("R2", "sq_vld", sq_vld, 1);
    chk("R10", "stage_squash_req", stage_squash_req, 1);
    chk("R2", "sq_seq", sq_seq, 16'h21);
    chk("R2", "sq_mispc", sq_mispc, 32'h1000);
    chk("R2", "sq_npc", sq_npc, 32'h2000);
    chk("R2", "sq_mispred", sq_mispred, 1);
    chk("R3", "sq_taken target far", sq_taken, 1);
    chk("R6", "no iq report", iq_viol_vld, 0);
    clear_slots(); b_vld = 4'b0001; b_ctrl[0] = 1'b1; b_pt[0] = 1'b1;
    b_pc[0] = 32'h3000; b_tgt[0] = 32'h3004; b_pnpc[0] = 32'h4000;
    step(); e_pt++;
    chk("R3", "sq_taken fall-through", sq_taken, 0);
    chk("R2", "sq_npc fall-through", sq_npc, 32'h3004);
    chk_counts("R9");
  endtask

  task automatic t_viol();
    clear_slots(); b_vld = 4'b0001; b_mem[0] = 1'b1; b_lv[0] = 1'b1;
    b_seq[0] = 16'h7; b_tgt[0] = 32'h500; viol_src = 16'h9;
    step(); e_mv++;
    chk("R4", "sq_vld", sq_vld, 1);
    chk("R4", "sq_seq", sq_seq, 16'h7);
    chk("R4", "sq_npc", sq_npc, 32'h500);
    chk("R4", "sq_mispred", sq_mispred, 0);
    chk("R4", "sq_mispc", sq_mispc, 0);
    chk("R4", "sq_taken", sq_taken, 0);
    chk("R6", "iq_viol_vld", iq_viol_vld, 1);
    chk("R6", "iq_inst_seq", iq_inst_seq, 16'h7);
    chk("R6", "iq_src_seq", iq_src_seq, 16'h9);
    chk_counts("R9");
  endtask

  task automatic t_prio();
    clear_slots(); b_vld = 4'b0001; b_ctrl[0] = 1'b1; b_mem[0] = 1'b1; b_lv[0] = 1'b1;
    b_tgt[0] = 32'h8000; viol_src = 16'h3;
    step();
    chk("R5", "mispredict wins", sq_mispred, 1);
    chk("R5", "no iq report", iq_viol_vld, 0);
    chk_counts("R5");
  endtask

  task automatic t_oldest();
    clear_slots(); b_vld = 4'hF;
    b_mem[0] = 1'b1; b_lv[0] = 1'b1; b_seq[0] = 16'd50;
    b_ctrl[2] = 1'b1; b_pt[2] = 1'b1; b_seq[2] = 16'd30; b_pc[2] = 32'h600; b_tgt[2] = 32'h604;
    b_ctrl[3] = 1'b1; b_pt[3] = 1'b1; b_seq[3] = 16'd40; b_tgt[3] = 32'h700;
    step(); e_pt += 2; e_mv++;
    chk("R7", "sq_seq oldest", sq_seq, 30);
    chk("R7", "kind of oldest", sq_mispred, 1);
    chk("R7", "sq_mispc oldest", sq_mispc, 32'h600);
    chk_counts("R9");
  endtask

  task automatic t_sqd();
    clear_slots(); b_vld = 4'b0011; b_sqd[0] = 1'b1; b_ctrl[0] = 1'b1; b_tgt[0] = 32'hF000;
    b_mem[0] = 1'b1; b_lv[0] = 1'b1;
    step(); e_sq++;
    chk("R8", "squashed slot silent", sq_vld, 0);
    chk("R8", "pass_mask", pass_mask, 4'b0001);
    chk_counts("R8");
    clear_slots(); step();
    chk("R10", "idle sq_seq zero", sq_seq, 0);
    chk("R10", "idle sq_npc zero", sq_npc, 0);
    chk("R10", "idle request low", stage_squash_req, 0);
  endtask

  initial begin
    clear_slots();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_limits();
    t_branch();
    t_viol();
    t_prio();
    t_oldest();
    t_sqd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule